// File: doc/BRIEF.md
# Synchronized Clock Stop Controller

This block sits between the clock sources of a board-level clock generator and its output pins. It gates three groups of output clocks (processor, memory and bus), one gate per output, so that each output can be started or stopped without ever producing a shortened high pulse. Each output runs only when its software enable bit asks for it and its group is not held off by a hardware halt pin. A stopped output is parked low.

Requests do not act at once. A change of gate state is first armed by a rising edge of a free-running bus reference clock, and then committed on the next falling edge of the source clock of the group being gated. Because the gate only moves while its source is low, every high pulse that reaches an output has the full source width. A mode input can disable the halt pins, a power input stops every output immediately, and a settle timer reports when the clocks may be trusted after power returns.

The whole block runs in one fast sampling clock domain: the reference and source clocks enter as sampled levels, and each output is a register driven by the gate and the sampled source level.

Top module: `clk_stop_ctrl`

## Requirements
- R1: A stopped output is held low; after reset every output is low.
- R2: A gate changes state only when the sampled reference clock has risen (0 then 1) with the request differing from the gate, followed by a falling edge of that group's source; an output then follows its source with one cycle of latency.
- R3: An output runs only when its enable bit is 1 and its group halt is not active; disabling single bits of an enable vector stops exactly those outputs.
- R4: With `pin_mode` = 0 the halt pins are active low; with `pin_mode` = 1 both halt pins are ignored and count as not asserted.
- R5: `cpu_halt_n` low stops only the processor group and `pci_halt_n` low stops only the bus group; the memory group is affected by neither pin.
- R6: While `power_on` is 0 every output is low from the next cycle on, and all gates are cleared; outputs resume through the normal arming sequence when power returns.
- R7: `clocks_valid` is 0 while `power_on` is 0 or after reset, and becomes 1 after `SETTLE_CYCLES` consecutive cycles of `power_on` = 1.
- R8: Every high pulse on an output that is not cut by power-down has the same width as the source high time.
- R9: A request that returns to the current gate state before it commits leaves the output unchanged; with no reference rising edge no change commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Sampled free-running bus reference clock |
| cpu_src | input | 1 | Sampled processor group source clock |
| mem_src | input | 1 | Sampled memory group source clock |
| pci_src | input | 1 | Sampled bus group source clock |
| cpu_en | input | N_CPU | Per-output enables, processor group |
| mem_en | input | N_MEM | Per-output enables, memory group |
| pci_en | input | N_PCI | Per-output enables, bus group |
| pin_mode | input | 1 | 0: halt pins active, 1: halt pins ignored |
| cpu_halt_n | input | 1 | Active-low halt of processor group |
| pci_halt_n | input | 1 | Active-low halt of bus group |
| power_on | input | 1 | 0 stops all outputs and restarts settling |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| mem_clk_o | output | N_MEM | Gated memory clocks |
| pci_clk_o | output | N_PCI | Gated bus clocks |
| clocks_valid | output | 1 | High once the settle time has elapsed |

## Verification
The bench builds the block with four processor outputs, four memory outputs, six bus outputs and `SETTLE_CYCLES` = 50, so the settle edge and its restart after power-down fall within a few dozen cycles instead of the tens of thousands the default would take. Source clocks of period 4 and 8 with a reference of period 8 keep every arm-and-commit window short, so each group change can be counted pulse by pulse over a fixed window, and the reference can be halted to hold a reverted request uncommitted.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

    typedef enum logic [1:0] {
        GRP_CPU = 2'd0,
        GRP_MEM = 2'd1,
        GRP_PCI = 2'd2
    } clk_group_e;

    localparam int NUM_GROUPS = 3;

    // Gate state of one output lane.
    typedef struct packed {
        logic gate;   // 1: high phases of the source pass through
        logic armed;  // reference edge seen with a pending change
    } lane_state_t;

    // A halt pin blocks its group only when the pins are in use.
    function automatic logic halt_active(input logic use_pins_off, input logic halt_n);
        return !use_pins_off && !halt_n;
    endfunction

endpackage

// File: rtl/cs_edge_sense.sv
module cs_edge_sense #(
    parameter int W       = 1,
    parameter bit RISING  = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] edge_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sig_i;
    end

    generate
        if (RISING) begin : g_rise
            assign edge_o = sig_i & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~sig_i & prev_q;
        end
    endgenerate
endmodule

// File: rtl/cs_gate_lane.sv
module cs_gate_lane
    import clk_stop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic power_on,
    input  logic want,
    input  logic ref_rise,
    input  logic src_fall,
    input  logic src_lvl,
    output logic clk_o
);
    lane_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst || !power_on) begin
            st_q  <= '0;
            clk_o <= 1'b0;
        end else begin
            if (st_q.armed && src_fall) begin
                st_q.gate  <= want;
                st_q.armed <= 1'b0;
            end else if (ref_rise && (want != st_q.gate)) begin
                st_q.armed <= 1'b1;
            end
            clk_o <= st_q.gate & src_lvl;
        end
    end

    // R1: a closed gate yields a low output on the next cycle
    a_r1_stopped_low : assert property (@(posedge clk) disable iff (rst)
        !st_q.gate |=> !clk_o);

    // R2: gate moves only on a falling source edge after arming
    a_r2_commit_order : assert property (@(posedge clk) disable iff (rst)
        ((st_q.gate != $past(st_q.gate)) && $past(power_on))
        |-> $past(src_fall && st_q.armed));

    // R8: an output only drops because its source dropped
    a_r8_full_high : assert property (@(posedge clk) disable iff (rst)
        (!clk_o && $past(clk_o) && $past(power_on)) |-> $past(!src_lvl));
endmodule

// File: rtl/cs_lane_group.sv
module cs_lane_group #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         power_on,
    input  logic [N-1:0] want,
    input  logic         ref_rise,
    input  logic         src_fall,
    input  logic         src_lvl,
    output logic [N-1:0] clk_o
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        cs_gate_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .power_on (power_on),
            .want     (want[i]),
            .ref_rise (ref_rise),
            .src_fall (src_fall),
            .src_lvl  (src_lvl),
            .clk_o    (clk_o[i])
        );
    end
endmodule

// File: rtl/cs_settle_timer.sv
module cs_settle_timer #(
    parameter int SETTLE_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic power_on,
    output logic valid
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !power_on)   cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign valid = (cnt_q == LIMIT);

    // R7: loss of power clears the ready flag
    a_r7_valid_drops : assert property (@(posedge clk) disable iff (rst)
        !power_on |=> !valid);

    // R7: once ready, the flag holds while power stays on
    a_r7_valid_holds : assert property (@(posedge clk) disable iff (rst)
        (valid && power_on) |=> valid);
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
    import clk_stop_pkg::*;
#(
    parameter int N_CPU         = 4,
    parameter int N_MEM         = 4,
    parameter int N_PCI         = 6,
    parameter int SETTLE_CYCLES = 20000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_clk_in,
    input  logic             cpu_src,
    input  logic             mem_src,
    input  logic             pci_src,
    input  logic [N_CPU-1:0] cpu_en,
    input  logic [N_MEM-1:0] mem_en,
    input  logic [N_PCI-1:0] pci_en,
    input  logic             pin_mode,
    input  logic             cpu_halt_n,
    input  logic             pci_halt_n,
    input  logic             power_on,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_MEM-1:0] mem_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             clocks_valid
);
    localparam int CPU_IX = int'(GRP_CPU);
    localparam int MEM_IX = int'(GRP_MEM);
    localparam int PCI_IX = int'(GRP_PCI);

    logic                  ref_rise;
    logic [NUM_GROUPS-1:0] src_lvl;
    logic [NUM_GROUPS-1:0] src_fall;
    logic                  cpu_block, pci_block;
    logic [N_CPU-1:0]      cpu_want;
    logic [N_MEM-1:0]      mem_want;
    logic [N_PCI-1:0]      pci_want;

    assign src_lvl[CPU_IX] = cpu_src;
    assign src_lvl[MEM_IX] = mem_src;
    assign src_lvl[PCI_IX] = pci_src;

    cs_edge_sense #(.W(1), .RISING(1'b1)) u_ref_edge (
        .clk (clk), .rst (rst), .sig_i (ref_clk_in), .edge_o (ref_rise)
    );

    cs_edge_sense #(.W(NUM_GROUPS), .RISING(1'b0)) u_src_edge (
        .clk (clk), .rst (rst), .sig_i (src_lvl), .edge_o (src_fall)
    );

    assign cpu_block = halt_active(pin_mode, cpu_halt_n);
    assign pci_block = halt_active(pin_mode, pci_halt_n);

    assign cpu_want = cpu_en & {N_CPU{!cpu_block}};
    assign mem_want = mem_en;
    assign pci_want = pci_en & {N_PCI{!pci_block}};

    cs_lane_group #(.N(N_CPU)) u_cpu_grp (
        .clk (clk), .rst (rst), .power_on (power_on), .want (cpu_want),
        .ref_rise (ref_rise), .src_fall (src_fall[CPU_IX]),
        .src_lvl (src_lvl[CPU_IX]), .clk_o (cpu_clk_o)
    );

    cs_lane_group #(.N(N_MEM)) u_mem_grp (
        .clk (clk), .rst (rst), .power_on (power_on), .want (mem_want),
        .ref_rise (ref_rise), .src_fall (src_fall[MEM_IX]),
        .src_lvl (src_lvl[MEM_IX]), .clk_o (mem_clk_o)
    );

    cs_lane_group #(.N(N_PCI)) u_pci_grp (
        .clk (clk), .rst (rst), .power_on (power_on), .want (pci_want),
        .ref_rise (ref_rise), .src_fall (src_fall[PCI_IX]),
        .src_lvl (src_lvl[PCI_IX]), .clk_o (pci_clk_o)
    );

    cs_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk (clk), .rst (rst), .power_on (power_on), .valid (clocks_valid)
    );

    // R6: power-down silences every output on the next cycle
    a_r6_powerdown_low : assert property (@(posedge clk) disable iff (rst)
        !power_on |=> (cpu_clk_o == '0 && mem_clk_o == '0 && pci_clk_o == '0));
endmodule

// File: tb/clk_stop_ctrl_tb_top.sv
module clk_stop_ctrl_tb_top;
    localparam int N_CPU  = 4;
    localparam int N_MEM  = 4;
    localparam int N_PCI  = 6;
    localparam int SETTLE = 50;
    localparam int WIN    = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, ref_clk_in, cpu_src, mem_src, pci_src;
    logic [N_CPU-1:0] cpu_en;
    logic [N_MEM-1:0] mem_en;
    logic [N_PCI-1:0] pci_en;
    logic pin_mode, cpu_halt_n, pci_halt_n, power_on;
    logic [N_CPU-1:0] cpu_clk_o;
    logic [N_MEM-1:0] mem_clk_o;
    logic [N_PCI-1:0] pci_clk_o;
    logic clocks_valid;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // Source generation: cpu/mem period 4, pci and reference period 8.
    logic [2:0] ph = '0;
    bit ref_run = 1;
    always @(negedge clk) ph <= ph + 3'd1;
    assign cpu_src    = ph[1];
    assign mem_src    = ph[1];
    assign pci_src    = ph[2];
    assign ref_clk_in = ref_run & (ph[2] ^ ph[1]);

    clk_stop_ctrl #(
        .N_CPU(N_CPU), .N_MEM(N_MEM), .N_PCI(N_PCI), .SETTLE_CYCLES(SETTLE)
    ) dut_i (
        .clk(clk), .rst(rst), .ref_clk_in(ref_clk_in),
        .cpu_src(cpu_src), .mem_src(mem_src), .pci_src(pci_src),
        .cpu_en(cpu_en), .mem_en(mem_en), .pci_en(pci_en),
        .pin_mode(pin_mode), .cpu_halt_n(cpu_halt_n), .pci_halt_n(pci_halt_n),
        .power_on(power_on), .cpu_clk_o(cpu_clk_o), .mem_clk_o(mem_clk_o),
        .pci_clk_o(pci_clk_o), .clocks_valid(clocks_valid)
    );

    // ---------------- scoreboard ----------------
    typedef struct {
        string      tag;
        int         grp;    // 0 cpu, 1 mem, 2 pci
        logic [7:0] mask;   // bits expected to run
    } win_item_t;

    win_item_t exp_q[$];
    bit mon_busy = 0;

    function automatic logic [7:0] grp_out(input int g);
        case (g)
            0:       return 8'(cpu_clk_o);
            1:       return 8'(mem_clk_o);
            default: return 8'(pci_clk_o);
        endcase
    endfunction

    function automatic int grp_width(input int g);
        return (g == 0) ? N_CPU : (g == 1) ? N_MEM : N_PCI;
    endfunction

    function automatic int grp_pulses(input int g);
        return (g == 2) ? WIN / 8 : WIN / 4;
    endfunction

    task automatic push_group(input string tag, input int grp, input logic [7:0] mask);
        win_item_t it;
        it.tag = tag; it.grp = grp; it.mask = mask;
        exp_q.push_back(it);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (exp_q.size() != 0 || mon_busy) @(negedge clk);
    endtask

    task automatic expect_group(input string tag, input int grp, input logic [7:0] mask);
        push_group(tag, grp, mask);
        wait_idle();
    endtask

    // Monitor: counts rising edges per output over a window.
    initial begin
        forever begin
            win_item_t it;
            int cnt [8];
            logic [7:0] prev, cur;
            while (exp_q.size() == 0) @(negedge clk);
            it = exp_q.pop_front();
            mon_busy = 1;
            for (int b = 0; b < 8; b++) cnt[b] = 0;
            @(negedge clk);
            prev = grp_out(it.grp);
            repeat (WIN) begin
                @(negedge clk);
                cur = grp_out(it.grp);
                for (int b = 0; b < 8; b++) if (cur[b] && !prev[b]) cnt[b]++;
                prev = cur;
            end
            for (int b = 0; b < grp_width(it.grp); b++) begin
                int e;
                e = it.mask[b] ? grp_pulses(it.grp) : 0;
                n_cmp++;
                if (cnt[b] != e) begin
                    n_bad++;
                    $display("FAIL %s group %0d bit %0d: pulses %0d expected %0d",
                             it.tag, it.grp, b, cnt[b], e);
                end
            end
            mon_busy = 0;
        end
    end

    task automatic check_val(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // R8: width of every completed high pulse (cpu bit 0: 2, pci bit 0: 4).
    int  run_c = 0, run_p = 0;
    always @(negedge clk) begin
        if (cpu_clk_o[0]) run_c++;
        else begin
            if (run_c > 0 && power_on && !rst) begin
                n_cmp++;
                if (run_c != 2) begin
                    n_bad++;
                    $display("FAIL R8 cpu pulse width: got %0d expected 2", run_c);
                end
            end
            run_c = 0;
        end
        if (pci_clk_o[0]) run_p++;
        else begin
            if (run_p > 0 && power_on && !rst) begin
                n_cmp++;
                if (run_p != 4) begin
                    n_bad++;
                    $display("FAIL R8 pci pulse width: got %0d expected 4", run_p);
                end
            end
            run_p = 0;
        end
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- driver ----------------
    initial begin
        rst = 1; power_on = 1; pin_mode = 0;
        cpu_halt_n = 1; pci_halt_n = 1;
        cpu_en = '1; mem_en = '1; pci_en = '1;
        settle(4);
        // R1 / R7: reset state
        check_val("R1 reset cpu low", 32'(cpu_clk_o), 0);
        check_val("R1 reset mem low", 32'(mem_clk_o), 0);
        check_val("R1 reset pci low", 32'(pci_clk_o), 0);
        check_val("R7 reset valid low", 32'(clocks_valid), 0);
        rst = 0;
        settle(40);
        check_val("R7 valid before settle", 32'(clocks_valid), 0);
        settle(15);
        check_val("R7 valid after settle", 32'(clocks_valid), 1);

        // R2: all groups armed and running
        expect_group("R2 cpu running", 0, 8'h0F);
        expect_group("R2 mem running", 1, 8'h0F);
        expect_group("R2 pci running", 2, 8'h3F);

        // R3 / R1: partial enable vector
        cpu_en = 4'b0101;
        settle(30);
        expect_group("R3 cpu partial enable", 0, 8'h05);

        // R5: processor halt
        cpu_en = '1; cpu_halt_n = 0;
        settle(30);
        expect_group("R5 cpu halted", 0, 8'h00);
        expect_group("R5 mem unaffected by cpu halt", 1, 8'h0F);
        expect_group("R5 pci unaffected by cpu halt", 2, 8'h3F);

        // R5: bus halt as well
        pci_halt_n = 0;
        settle(30);
        expect_group("R5 pci halted", 2, 8'h00);
        expect_group("R5 mem unaffected by pci halt", 1, 8'h0F);

        // R4: pins ignored in mode 1
        pin_mode = 1;
        settle(30);
        expect_group("R4 mode1 cpu runs", 0, 8'h0F);
        expect_group("R4 mode1 pci runs", 2, 8'h3F);
        pin_mode = 0;
        settle(30);
        expect_group("R4 mode0 cpu halted again", 0, 8'h00);

        // R3: pins released
        cpu_halt_n = 1; pci_halt_n = 1;
        settle(30);
        expect_group("R3 cpu restart", 0, 8'h0F);
        expect_group("R3 pci restart", 2, 8'h3F);

        // R9: request reverted while no reference edge occurs
        ref_run = 0;
        settle(4);
        cpu_en = '0;
        push_group("R9 no commit without reference", 0, 8'h0F);
        wait_idle();
        cpu_en = '1;
        settle(10);
        ref_run = 1;
        settle(30);
        expect_group("R9 reverted request no change", 0, 8'h0F);

        // R6: power-down
        power_on = 0;
        settle(2);
        check_val("R6 cpu low in power-down", 32'(cpu_clk_o), 0);
        check_val("R6 mem low in power-down", 32'(mem_clk_o), 0);
        check_val("R6 pci low in power-down", 32'(pci_clk_o), 0);
        check_val("R7 valid low in power-down", 32'(clocks_valid), 0);
        expect_group("R6 mem stopped", 1, 8'h00);
        power_on = 1;
        settle(40);
        check_val("R7 valid low while resettling", 32'(clocks_valid), 0);
        settle(15);
        check_val("R7 valid after resettling", 32'(clocks_valid), 1);
        expect_group("R6 cpu resumes", 0, 8'h0F);
        expect_group("R6 mem resumes", 1, 8'h0F);
        expect_group("R6 pci resumes", 2, 8'h3F);

        done = 1;
        report();
    end
endmodule